// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers eight active-high interrupt request lines, records each rising edge as a pending request, and selects one request for a processor. It asserts a single interrupt output when a pending, unmasked request outranks every line already in service. The processor answers with a one-cycle acknowledge. The controller then moves the granted line from pending to in-service and presents an 8-bit vector on its data output for one cycle. Line 0 has the highest priority and line 7 the lowest.

In-service state makes nesting possible. A more urgent request interrupts a handler that is already running. A request of equal or lower rank waits as pending until software issues an end-of-interrupt command, which retires the most urgent in-service line. A small write port holds a per-line mask and the upper five bits of the vector.

Top module: `prio_intc`

## Requirements
- R1: After a synchronous reset, `int_out` and `vec_valid` are 0, `vec_out` is 0, every mask bit is clear and the vector base is 0.
- R2: A request is latched only on a 0-to-1 transition of its `irq_in` line. A line held high after its grant does not request again.
- R3: `int_out` goes high in the cycle after a rising edge is sampled, provided that line is unmasked and no line is in service.
- R4: If `ack_in` is sampled high while `int_out` is high, `vec_valid` is 1 for exactly the next cycle. During that cycle `vec_out` = {base[4:0], line[2:0]} for the lowest-numbered pending unmasked line. At all other times `vec_out` is 0.
- R5: If `ack_in` is sampled while `int_out` is low, it has no effect and produces no vector.
- R6: A line whose mask bit is 1 still latches its request but cannot raise `int_out`. Clearing the mask bit later lets that request through.
- R7: While line k is in service, a pending line j raises `int_out` only if j < k. Equal or lower-priority lines stay pending.
- R8: An end-of-interrupt command clears the lowest-numbered set in-service bit. A request it had been holding back is offered next.
- R9: A config write with `cfg_sel` 2'b00 loads the mask from `cfg_wdata` (bit i masks line i). With 2'b01 it loads the vector base from `cfg_wdata[7:3]`. With 2'b10 it issues an end-of-interrupt and ignores the data. 2'b11 does nothing.
- R10: An accepted acknowledge clears the granted line's pending request and sets its in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request lines, bit 0 most urgent |
| cfg_we | input | 1 | Config write strobe |
| cfg_sel | input | 2 | Config target: 00 mask, 01 base, 10 end-of-interrupt |
| cfg_wdata | input | 8 | Config write data |
| ack_in | input | 1 | Processor acknowledge, one cycle |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector, non-zero only while vec_valid |
| vec_valid | output | 1 | Vector is presented this cycle |

## Verification
The selection logic is tested with four kinds of input: a single request, two lines rising in the same cycle, a more urgent line arriving during service, and a less urgent or equal line arriving during service. Together these separate a correct lowest-index pick from a reversed or first-come order, and real pre-emption from plain queuing. A masked line that is unmasked later shows that masking blocks delivery but not latching. A line held high through its own end-of-interrupt shows that requests are edge-based rather than level-based. An acknowledge sent with no interrupt pending, and a change of vector base, check the vector path apart from the selection path.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
    localparam int NLINES = 8;
    localparam int IDX_W  = $clog2(NLINES);
    localparam int VEC_W  = 8;
    localparam int BASE_W = VEC_W - IDX_W;

    typedef enum logic [1:0] {
        CFG_MASK = 2'b00,
        CFG_BASE = 2'b01,
        CFG_EOI  = 2'b10,
        CFG_NOP  = 2'b11
    } cfg_sel_e;

    typedef struct packed {
        logic             found;
        logic [IDX_W-1:0] idx;
    } pick_t;

    function automatic logic [NLINES-1:0] line_bit(input logic [IDX_W-1:0] i);
        return NLINES'(1) << i;
    endfunction
endpackage

// File: rtl/intc_pick.sv
module intc_pick #(
    parameter int WIDTH = 8,
    localparam int IW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] bits,
    output logic             found,
    output logic [IW-1:0]    idx
);
    // lowest set index wins: scan downward so the last hit is the smallest
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/intc_req_latch.sv
module intc_req_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] irq,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] req
);
    logic [WIDTH-1:0] irq_q;
    logic [WIDTH-1:0] rise;

    assign rise = irq & ~irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
            req   <= '0;
        end else begin
            irq_q <= irq;
            req   <= (req & ~clr) | rise;
        end
    end

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_chk
            // R2: a sampled rising edge always leaves the request pending
            a_r2_edge_latches: assert property (@(posedge clk) disable iff (rst)
                (irq[g] && !irq_q[g]) |=> req[g]);
            // R2: no request appears without an edge
            a_r2_no_spurious_req: assert property (@(posedge clk) disable iff (rst)
                (!req[g] && !(irq[g] && !irq_q[g])) |=> !req[g]);
        end
    endgenerate
endmodule

// File: rtl/intc_service.sv
module intc_service
    import prio_intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              grant,
    input  logic [IDX_W-1:0]  grant_idx,
    input  logic              eoi,
    input  logic [BASE_W-1:0] base,
    output logic [NLINES-1:0] isr,
    output pick_t             isr_top,
    output logic [VEC_W-1:0]  vec_out,
    output logic              vec_valid
);
    logic [NLINES-1:0] set_mask;
    logic [NLINES-1:0] clr_mask;

    intc_pick #(.WIDTH(NLINES)) u_top (
        .bits  (isr),
        .found (isr_top.found),
        .idx   (isr_top.idx)
    );

    assign set_mask = grant ? line_bit(grant_idx) : '0;
    assign clr_mask = (eoi && isr_top.found) ? line_bit(isr_top.idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            isr       <= '0;
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            isr       <= (isr & ~clr_mask) | set_mask;
            vec_valid <= grant;
            vec_out   <= grant ? {base, grant_idx} : '0;
        end
    end

    // R4: vector appears only right after an accepted acknowledge
    a_r4_vec_after_grant: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(grant));
    // R4: idle vector output is zero
    a_r4_vec_zero_idle: assert property (@(posedge clk) disable iff (rst)
        !vec_valid |-> (vec_out == '0));
    // R10: a grant adds exactly one in-service line
    a_r10_grant_sets_isr: assert property (@(posedge clk) disable iff (rst)
        (grant && !eoi) |=> ($countones(isr) == $past($countones(isr)) + 1));
    // R8: end-of-interrupt retires exactly one line when any is in service
    a_r8_eoi_clears_one: assert property (@(posedge clk) disable iff (rst)
        (eoi && !grant && (isr != '0)) |=> ($countones(isr) == $past($countones(isr)) - 1));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] irq_in,
    input  logic       cfg_we,
    input  logic [1:0] cfg_sel,
    input  logic [7:0] cfg_wdata,
    input  logic       ack_in,
    output logic       int_out,
    output logic [7:0] vec_out,
    output logic       vec_valid
);
    logic [NLINES-1:0] mask_q;
    logic [BASE_W-1:0] base_q;
    logic [NLINES-1:0] req;
    logic [NLINES-1:0] pend;
    logic [NLINES-1:0] clr;
    logic [NLINES-1:0] isr;
    pick_t             best;
    pick_t             isr_top;
    cfg_sel_e          sel;
    logic              grant;
    logic              eoi;

    assign sel = cfg_sel_e'(cfg_sel);
    assign eoi = cfg_we && (sel == CFG_EOI);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            base_q <= '0;
        end else if (cfg_we) begin
            case (sel)
                CFG_MASK: mask_q <= cfg_wdata[NLINES-1:0];
                CFG_BASE: base_q <= cfg_wdata[VEC_W-1:IDX_W];
                default:  ;
            endcase
        end
    end

    intc_req_latch #(.WIDTH(NLINES)) u_req (
        .clk (clk),
        .rst (rst),
        .irq (irq_in),
        .clr (clr),
        .req (req)
    );

    assign pend = req & ~mask_q;

    intc_pick #(.WIDTH(NLINES)) u_best (
        .bits  (pend),
        .found (best.found),
        .idx   (best.idx)
    );

    assign int_out = best.found && (!isr_top.found || (best.idx < isr_top.idx));
    assign grant   = ack_in && int_out;
    assign clr     = grant ? line_bit(best.idx) : '0;

    intc_service u_svc (
        .clk       (clk),
        .rst       (rst),
        .grant     (grant),
        .grant_idx (best.idx),
        .eoi       (eoi),
        .base      (base_q),
        .isr       (isr),
        .isr_top   (isr_top),
        .vec_out   (vec_out),
        .vec_valid (vec_valid)
    );

    // R6: the interrupt output needs an unmasked latched request
    a_r6_int_needs_unmasked: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((req & ~mask_q) != '0));
    // R5: acknowledge with interrupt low leaves no vector behind
    a_r5_stray_ack_ignored: assert property (@(posedge clk) disable iff (rst)
        (ack_in && !int_out) |=> !vec_valid);
    // R10: the granted line stops pending
    a_r10_grant_clears_req: assert property (@(posedge clk) disable iff (rst)
        grant |=> ((req & $past(clr)) == '0) || ((irq_in & $past(clr)) != '0));
endmodule

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq_in;
    logic       cfg_we;
    logic [1:0] cfg_sel;
    logic [7:0] cfg_wdata;
    logic       ack_in;
    logic       int_out;
    logic [7:0] vec_out;
    logic       vec_valid;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    prio_intc u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ack_in(ack_in), .int_out(int_out),
        .vec_out(vec_out), .vec_valid(vec_valid)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        step();
        cfg_we = 1'b0; cfg_sel = 2'b11; cfg_wdata = '0;
    endtask

    task automatic do_ack(input logic [7:0] expv);
        exp_q.push_back(expv);
        ack_in = 1'b1;
        step();
        ack_in = 1'b0;
    endtask

    // monitor: every vector produced must match the next expected item
    always @(negedge clk) begin
        if (!rst && vec_valid) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected vector", vec_out, 8'h00);
                if (vec_out == 8'h00) begin
                    n_fail++;
                    $display("FAIL R5 vec_valid with no acknowledge actual=1 expected=0");
                end
            end else begin
                check("R4 vector value", vec_out, exp_q.pop_front());
            end
        end else if (!rst) begin
            if (vec_out !== 8'h00) begin
                check("R4 idle vector", vec_out, 8'h00);
            end
        end
    end

    initial begin
        rst = 1'b1; irq_in = '0; cfg_we = 1'b0; cfg_sel = 2'b11; cfg_wdata = '0; ack_in = 1'b0;
        repeat (3) step();
        check("R1 int_out after reset", {7'b0, int_out}, 8'h00);
        check("R1 vec_valid after reset", {7'b0, vec_valid}, 8'h00);
        check("R1 vec_out after reset", vec_out, 8'h00);
        rst = 1'b0;
        step();

        // R1: default mask clear and base zero: line 0 vector is 0x00
        irq_in[0] = 1'b1; step();
        check("R1 R3 int_out from line 0", {7'b0, int_out}, 8'h01);
        do_ack(8'h00);
        cfg_write(2'b10, 8'h00);
        irq_in[0] = 1'b0; step();

        // R9: base from wdata[7:3]
        cfg_write(2'b01, 8'hA7);
        irq_in[5] = 1'b1; step();
        check("R3 int_out on single request", {7'b0, int_out}, 8'h01);
        do_ack(8'hA5);
        check("R10 int_out drops after grant", {7'b0, int_out}, 8'h00);
        cfg_write(2'b10, 8'hFF);
        step();
        check("R2 held line does not re-request", {7'b0, int_out}, 8'h00);
        irq_in[5] = 1'b0; step();

        // R4: two lines rise together, lower index first
        irq_in[3] = 1'b1; irq_in[6] = 1'b1; step();
        check("R4 int_out with two pending", {7'b0, int_out}, 8'h01);
        do_ack(8'hA3);
        check("R7 lower line waits while 3 in service", {7'b0, int_out}, 8'h00);
        cfg_write(2'b10, 8'h00);
        check("R8 eoi releases line 6", {7'b0, int_out}, 8'h01);
        do_ack(8'hA6);
        cfg_write(2'b10, 8'h00);
        irq_in[3] = 1'b0; irq_in[6] = 1'b0; step();

        // R7: nesting, equal does not pre-empt, higher does
        irq_in[4] = 1'b1; step();
        do_ack(8'hA4);
        irq_in[4] = 1'b0; step();
        irq_in[4] = 1'b1; step();
        check("R7 equal line does not pre-empt", {7'b0, int_out}, 8'h00);
        irq_in[2] = 1'b1; step();
        check("R7 higher line pre-empts", {7'b0, int_out}, 8'h01);
        do_ack(8'hA2);
        check("R7 nested grant leaves nothing above", {7'b0, int_out}, 8'h00);
        cfg_write(2'b10, 8'h00);
        check("R8 eoi retires line 2 only", {7'b0, int_out}, 8'h00);
        cfg_write(2'b10, 8'h00);
        check("R8 pending line 4 offered after eoi", {7'b0, int_out}, 8'h01);
        do_ack(8'hA4);
        cfg_write(2'b10, 8'h00);
        irq_in = '0; step();

        // R5: stray acknowledge
        check("R5 idle before stray ack", {7'b0, int_out}, 8'h00);
        ack_in = 1'b1; step(); ack_in = 1'b0; step();
        check("R5 no vector after stray ack", {7'b0, vec_valid}, 8'h00);

        // R6: mask blocks delivery, not latching
        cfg_write(2'b00, 8'h02);
        irq_in[1] = 1'b1; step();
        check("R6 masked line silent", {7'b0, int_out}, 8'h00);
        irq_in[1] = 1'b0; step();
        cfg_write(2'b00, 8'h00);
        check("R6 unmasked latched line delivered", {7'b0, int_out}, 8'h01);
        do_ack(8'hA1);
        cfg_write(2'b10, 8'h00);

        // R9: new base, nop select leaves state
        cfg_write(2'b01, 8'h38);
        cfg_write(2'b11, 8'hFF);
        irq_in[7] = 1'b1; step();
        check("R9 nop select did not mask", {7'b0, int_out}, 8'h01);
        do_ack(8'h3F);
        cfg_write(2'b10, 8'h00);
        irq_in = '0;
        repeat (3) step();

        check("R4 all expected vectors seen", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule